// File: doc/BRIEF.md
# Keyed Watchdog Timer

A memory-mapped watchdog that counts down in units of an external 10 ms tick enable. The timer runs only while it is enabled and not held by debug mode. If it reaches zero, it asks for a system reset and records a timed-out code. Software keeps it alive by writing a 16-bit key to the feed register. Every control action is guarded by an exact key value: feeding, resuming, clearing the status and the two-step disable. A wrong value leaves the block unchanged.

One tick before the reset request, the block raises a warning event. The event reaches the interrupt pin only when its mask bit is set, and software can also set it directly through a force bit. The timed-out status sits in a register cleared only by power-on reset or by its clear key, so it survives the reset it provoked. A count register returns the remaining ticks. Its top bit flags the one cycle in which the counter has just been updated.

Top module: `keyed_watchdog`

## Requirements
- R1: After both resets, the disable-state register (0x0C) reads 0xDABE and the status register (0x10) reads 0x0000. The count (0x14) and timeout (0x04) both hold the default timeout, and irq and reset_req are low. A word read returns 0 when rd_en is low or when addr[1:0] is not zero.
- R2: Writing 0xFEED to 0x00 loads the counter from the timeout register. Any other value written there, and any write of the timeout register alone, leaves the count unchanged.
- R3: The timeout register (0x04) keeps wdata[14:0] and reads back with bit 15 at zero.
- R4: While enabled and not held by debug, each tick cycle lowers the count by one. While disabled, ticks leave the count unchanged.
- R5: Writing 0xCAFE to 0x0C disables the timer only when the bus write just before it was 0x2BAD to 0x08. Any other write in between cancels the pending first step, and a lone 0xCAFE is ignored. Register 0x0C reads 0xDABE while disabled and 0x0000 while enabled.
- R6: Writing 0xACED to 0x1C enables the timer. Any other value there is ignored.
- R7: A tick at count zero while active gives a reset_req pulse one cycle wide in the following cycle, reloads the count from the timeout register, and makes the status read 0xCFE8.
- R8: The timed-out status is unaffected by rst_n. It is cleared by por_n or by writing 0xE8B4 to 0x10. Other values written to 0x10 have no effect.
- R9: A tick at count one while active sets the warning event, read as bit 0 of 0x20. Writing 1 to that bit clears it. irq is high exactly when the event and bit 0 of the mask register 0x24 are both set.
- R10: While bit 0 of the force register 0x28 is 1, the warning event is set.
- R11: Bit 1 of 0x18 reads the dbg_mode input. While dbg_mode is high, the counter is frozen unless override bit 0 of 0x18 has been written to 1.
- R12: Register 0x14 returns the count in bits 14:0. Bit 15 is high only in the cycle right after a tick-driven decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset (status kept) |
| por_n | input | 1 | Active-low power-on reset for the timed-out status |
| addr | input | 6 | Byte address of the register |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Read data, combinational |
| tick | input | 1 | 10 ms tick enable, one cycle per tick |
| dbg_mode | input | 1 | Debug mode indication |
| irq | output | 1 | Masked warning interrupt |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The keyed registers are exercised with the right key, a wrong key, and the right key in the wrong context: a second-step disable with nothing before it, or with an unrelated write in between. These patterns separate exact-match decoding from partial decoding, and they show whether the disable step is remembered across other writes. The countdown is driven through the warning tick and the expiry tick, each with the mask off and on, so that a warning one tick late or early, a missing reload, and a reset pulse that is too wide all show at the pins. A system reset after expiry, and ticks under debug with and without the override, separate the sticky status from the ordinary state and frozen counting from running counting.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int AW          = 6,
  parameter int TW          = 15,
  parameter int DEF_TIMEOUT = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [15:0]   rdata,
  input  logic          tick,
  input  logic          dbg_mode,
  output logic          irq,
  output logic          reset_req
);

  localparam int WA = AW - 2;
  localparam logic [WA-1:0] A_FEED = WA'(0),  A_TMO  = WA'(1),  A_DIS1 = WA'(2);
  localparam logic [WA-1:0] A_DIS2 = WA'(3),  A_STAT = WA'(4),  A_CNT  = WA'(5);
  localparam logic [WA-1:0] A_DBG  = WA'(6),  A_RES  = WA'(7),  A_EVT  = WA'(8);
  localparam logic [WA-1:0] A_MASK = WA'(9),  A_FRC  = WA'(10);
  localparam logic [15:0] K_FEED = 16'hFEED, K_DIS1 = 16'h2BAD, K_DIS2 = 16'hCAFE;
  localparam logic [15:0] K_RES  = 16'hACED, K_CLR  = 16'hE8B4;
  localparam logic [15:0] C_OFF  = 16'hDABE, C_TOUT = 16'hCFE8;

  logic [TW-1:0] timeout_q, count_q;
  logic enabled_q, dis_armed_q, timed_out_q, upd_q, rst_req_q;
  logic evt_q, mask_q, force_q, dbg_ovr_q;

  wire [WA-1:0] sel   = addr[AW-1:2];
  wire          align = (addr[1:0] == 2'b00);
  wire          wr    = wr_en & align;
  wire feed_hit = wr && sel == A_FEED && wdata == K_FEED;
  wire active   = enabled_q & (~dbg_mode | dbg_ovr_q);
  wire step     = active & tick & ~feed_hit;
  wire expire   = step && count_q == '0;
  wire warn     = step && count_q == TW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_q   <= TW'(DEF_TIMEOUT);
      count_q     <= TW'(DEF_TIMEOUT);
      enabled_q   <= 1'b0;
      dis_armed_q <= 1'b0;
      upd_q       <= 1'b0;
      rst_req_q   <= 1'b0;
      evt_q       <= 1'b0;
      mask_q      <= 1'b0;
      force_q     <= 1'b0;
      dbg_ovr_q   <= 1'b0;
    end else begin
      upd_q     <= step && count_q != '0;
      rst_req_q <= expire;
      if (wr) dis_armed_q <= (sel == A_DIS1 && wdata == K_DIS1);
      if (wr && sel == A_DIS2 && wdata == K_DIS2 && dis_armed_q) enabled_q <= 1'b0;
      else if (wr && sel == A_RES && wdata == K_RES)              enabled_q <= 1'b1;
      if (wr && sel == A_TMO)  timeout_q <= wdata[TW-1:0];
      if (wr && sel == A_MASK) mask_q    <= wdata[0];
      if (wr && sel == A_FRC)  force_q   <= wdata[0];
      if (wr && sel == A_DBG)  dbg_ovr_q <= wdata[0];
      if (feed_hit)    count_q <= timeout_q;
      else if (expire) count_q <= timeout_q;
      else if (step)   count_q <= count_q - TW'(1);
      if (warn || force_q)                        evt_q <= 1'b1;
      else if (wr && sel == A_EVT && wdata[0])    evt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                          timed_out_q <= 1'b0;
    else if (expire)                                     timed_out_q <= 1'b1;
    else if (wr && sel == A_STAT && wdata == K_CLR)      timed_out_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (rd_en && align) begin
      case (sel)
        A_TMO:   rdata = 16'(timeout_q);
        A_DIS2:  rdata = enabled_q ? 16'h0000 : C_OFF;
        A_STAT:  rdata = timed_out_q ? C_TOUT : 16'h0000;
        A_CNT:   rdata = {upd_q, 15'(count_q)};
        A_DBG:   rdata = {14'd0, dbg_mode, dbg_ovr_q};
        A_EVT:   rdata = {15'd0, evt_q};
        A_MASK:  rdata = {15'd0, mask_q};
        A_FRC:   rdata = {15'd0, force_q};
        default: rdata = '0;
      endcase
    end
  end

  assign irq       = evt_q & mask_q;
  assign reset_req = rst_req_q;

  p_feed_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(feed_hit) |-> count_q == $past(timeout_q));
  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(active & tick) && !$past(feed_hit) |-> $stable(count_q));
  p_disable_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enabled_q) |-> $past(dis_armed_q) && $past(wr && sel == A_DIS2));
  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  p_status_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out_q) |-> reset_req);
  p_valid_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> $past(tick) && $past(active));

endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  logic clk = 0, rst_n = 0, por_n = 0, wr_en = 0, rd_en = 0, tick = 0, dbg_mode = 0;
  logic [5:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic irq, reset_req;
  int checks = 0, fails = 0;

  keyed_watchdog uut (.clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .tick(tick), .dbg_mode(dbg_mode),
    .irq(irq), .reset_req(reset_req));

  always #4 clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string req, logic [5:0] a, logic [15:0] exp);
    @(negedge clk); addr = a; rd_en = 1; #1;
    check(req, rdata, exp); rd_en = 0;
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
    @(negedge clk);
  endtask

  // op: 0 write, 1 read and compare, 2 ticks (count in data)
  localparam int NV = 29;
  localparam logic [43:0] VEC [NV] = '{
    {2'd1, 4'd1, 6'h0C, 16'h0000, 16'hDABE},  // R1
    {2'd1, 4'd1, 6'h10, 16'h0000, 16'h0000},  // R1
    {2'd1, 4'd1, 6'h14, 16'h0000, 16'h1770},  // R1
    {2'd0, 4'd3, 6'h04, 16'hFFFF, 16'h0000},
    {2'd1, 4'd3, 6'h04, 16'h0000, 16'h7FFF},  // R3
    {2'd0, 4'd3, 6'h04, 16'h0005, 16'h0000},
    {2'd1, 4'd2, 6'h14, 16'h0000, 16'h1770},  // R2
    {2'd0, 4'd2, 6'h00, 16'h1234, 16'h0000},
    {2'd1, 4'd2, 6'h14, 16'h0000, 16'h1770},  // R2
    {2'd0, 4'd2, 6'h00, 16'hFEED, 16'h0000},
    {2'd1, 4'd2, 6'h14, 16'h0000, 16'h0005},  // R2
    {2'd2, 4'd4, 6'h00, 16'h0001, 16'h0000},
    {2'd1, 4'd4, 6'h14, 16'h0000, 16'h0005},  // R4
    {2'd0, 4'd6, 6'h1C, 16'h1234, 16'h0000},
    {2'd1, 4'd6, 6'h0C, 16'h0000, 16'hDABE},  // R6
    {2'd0, 4'd6, 6'h1C, 16'hACED, 16'h0000},
    {2'd1, 4'd6, 6'h0C, 16'h0000, 16'h0000},  // R6
    {2'd2, 4'd4, 6'h00, 16'h0002, 16'h0000},
    {2'd1, 4'd4, 6'h14, 16'h0000, 16'h0003},  // R4
    {2'd0, 4'd5, 6'h08, 16'h2BAD, 16'h0000},
    {2'd0, 4'd5, 6'h24, 16'h0000, 16'h0000},
    {2'd0, 4'd5, 6'h0C, 16'hCAFE, 16'h0000},
    {2'd1, 4'd5, 6'h0C, 16'h0000, 16'h0000},  // R5
    {2'd0, 4'd5, 6'h0C, 16'hCAFE, 16'h0000},
    {2'd1, 4'd5, 6'h0C, 16'h0000, 16'h0000},  // R5
    {2'd0, 4'd5, 6'h08, 16'h2BAD, 16'h0000},
    {2'd0, 4'd5, 6'h0C, 16'hCAFE, 16'h0000},
    {2'd1, 4'd5, 6'h0C, 16'h0000, 16'hDABE},  // R5
    {2'd1, 4'd1, 6'h0D, 16'h0000, 16'h0000}   // R1 misaligned
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; por_n = 1;
    check("R1 irq", {15'd0, irq}, 16'h0);
    check("R1 reset_req", {15'd0, reset_req}, 16'h0);
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][43:42])
        2'd0: wr(VEC[i][37:32], VEC[i][31:16]);
        2'd1: rd($sformatf("R%0d vec%0d", VEC[i][41:38], i), VEC[i][37:32], VEC[i][15:0]);
        default: tick_n(int'(VEC[i][31:16]));
      endcase
    end
    tick_n(1);
    rd("R4 disabled hold", 6'h14, 16'h0003);

    // R9 warning and R7 expiry
    wr(6'h1C, 16'hACED);
    wr(6'h24, 16'h0001);
    tick_n(2);
    rd("R9 no early event", 6'h20, 16'h0000);
    tick_n(1);
    rd("R9 event set", 6'h20, 16'h0001);
    check("R9 irq masked on", {15'd0, irq}, 16'h1);
    wr(6'h20, 16'h0001);
    check("R9 irq cleared", {15'd0, irq}, 16'h0);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; #1;
    check("R7 reset_req pulse", {15'd0, reset_req}, 16'h1);
    @(negedge clk); #1;
    check("R7 reset_req width", {15'd0, reset_req}, 16'h0);
    rd("R7 reload", 6'h14, 16'h0005);
    rd("R7 status", 6'h10, 16'hCFE8);

    // R8 sticky status across rst_n
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd("R8 status kept", 6'h10, 16'hCFE8);
    rd("R1 disabled after reset", 6'h0C, 16'hDABE);
    rd("R1 count default", 6'h14, 16'h1770);
    wr(6'h10, 16'h1234);
    rd("R8 wrong key", 6'h10, 16'hCFE8);
    wr(6'h10, 16'hE8B4);
    rd("R8 cleared", 6'h10, 16'h0000);

    // R10 force
    wr(6'h28, 16'h0001);
    rd("R10 forced event", 6'h20, 16'h0001);
    check("R9 irq masked off", {15'd0, irq}, 16'h0);
    wr(6'h24, 16'h0001);
    check("R10 irq forced", {15'd0, irq}, 16'h1);
    wr(6'h20, 16'h0001);
    rd("R10 held by force", 6'h20, 16'h0001);
    wr(6'h28, 16'h0000);
    wr(6'h20, 16'h0001);
    rd("R9 event clear", 6'h20, 16'h0000);

    // R11 debug
    wr(6'h04, 16'h0005);
    wr(6'h1C, 16'hACED);
    wr(6'h00, 16'hFEED);
    dbg_mode = 1;
    rd("R11 dbg read", 6'h18, 16'h0002);
    tick_n(1);
    rd("R11 frozen", 6'h14, 16'h0005);
    wr(6'h18, 16'h0001);
    rd("R11 override read", 6'h18, 16'h0003);
    tick_n(1);
    rd("R11 override runs", 6'h14, 16'h0004);
    dbg_mode = 0;

    // R12 valid flag
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; addr = 6'h14; rd_en = 1; #1;
    check("R12 flag set", rdata, 16'h8003);
    @(negedge clk); #1;
    check("R12 flag gone", rdata, 16'h0003);
    rd_en = 0;

    // R8 power-on clear
    wr(6'h04, 16'h0000);
    wr(6'h00, 16'hFEED);
    tick_n(1);
    rd("R7 status again", 6'h10, 16'hCFE8);
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    rd("R8 por clears", 6'h10, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule